// File: doc/BRIEF.md
# Write-Back Direct-Mapped Data Cache

This block sits between a processor load/store port and a memory port that moves one 32-bit word per transaction. It holds 2048 single-word lines (8 KB). Each line carries a tag made of the address bits above the index, plus a dirty flag. Loads and stores of byte, halfword or word size are served from the array when their address falls in the cached window. Any other access is forwarded to memory as a single transaction.

On a miss the controller checks the line the access maps to. If that line is dirty, the controller first writes it back to memory. It then fetches the new word, after which the access completes as a hit. Stores that hit only merge into the array and mark the line dirty. They reach memory later, when the line is evicted. Addresses reach the memory port untranslated. The processor side sees a single busy signal and must hold its request steady while that signal is high.

Top module: `dcwb_cache`

## Requirements
- R1: After reset every line holds tag word 0xFFFF0000 with the dirty flag clear, so the first access to any cached address misses, and because the line is clean it reaches memory only as a fill read of the word-aligned address.
- R2: The line index is address bits [12:2] and the tag is bits [31:13]. Two addresses 0x2000 apart use the same line and evict each other.
- R3: A load is cached only when (address & 0xFE000000) == 0x10000000, and a store only when address bits [31:28] == 1. Every other access makes exactly one memory transaction at the word-aligned address. A bypassed store uses byte enables for its lanes (bit n enables data bits [8n+7:8n]), and a bypassed load reads the whole word.
- R4: A cached access that hits completes in the cycle it is presented (busy low in that cycle) and causes no memory transaction.
- R5: On a miss whose line is dirty, the old word is first written to memory at {stored tag, index, 2'b00} with all four byte enables set. Only after that write is acknowledged is the fill read issued.
- R6: On a miss whose line is clean, no write-back occurs. The fill read is the only memory transaction.
- R7: A fill leaves the line clean. A store that completes on the line sets its dirty flag, so a store that misses is absorbed without any memory write.
- R8: A halfword store (size code 1) replicates data bits [15:0] into both halves and merges under the mask 0xFFFF << (8 × (address & 2)).
- R9: A byte store (size code 0) replicates data bits [7:0] into all four lanes and merges under the mask 0xFF << (8 × (address & 3)). Size code 2 is a full word.
- R10: A byte load returns (word >> 8 × (address & 3)) & 0xFF, and a halfword load returns (word >> 8 × (address & 2)) & 0xFFFF, both zero-extended. This holds for both cached and bypassed loads.
- R11: Busy stays high until the access completes. Once raised, the memory request and its address hold until the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, held until busy is low |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data, right-aligned |
| cpu_rdata | output | 32 | Load data, valid when req is high and busy is low |
| cpu_busy | output | 1 | Stall: access not yet complete |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | Memory transaction is a write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with ack |
| mem_ack | input | 1 | One-cycle transaction acknowledge |

## Verification
The bench goes after eviction order and addressing. It requires the write-back to carry the merged victim word to the address rebuilt from the old tag, and to come before the fill. A design that rebuilt the address from the new tag would overwrite the wrong word, and one that fetched first would lose the stores. It sweeps every byte and halfword lane for loads and stores and checks the merged word. A wrong mask or a missing replication would corrupt a neighbouring lane or place the data in the wrong lane. It also probes the asymmetric region edges: a load at 0x12000000 must bypass, while a store there is cached. A design that used one decode for both would hit where it should go to memory, or write through where it should absorb the store.

// File: rtl/dcwb_pkg.sv
package dcwb_pkg;

    localparam int AW    = 32;
    localparam int DW    = 32;
    localparam int OFF_W = 2;
    localparam int LANES = DW / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WB   = 2'd1,
        ST_FILL = 2'd2,
        ST_BYP  = 2'd3
    } cstate_e;

    typedef struct packed {
        logic [LANES-1:0] lanes;
        logic [DW-1:0]    mask;
        logic [DW-1:0]    data;
    } store_lane_t;

    function automatic acc_size_e to_size(input logic [1:0] code);
        case (code)
            2'd0:    return SZ_BYTE;
            2'd1:    return SZ_HALF;
            default: return SZ_WORD;
        endcase
    endfunction

    function automatic logic [LANES-1:0] lane_enables(input acc_size_e sz,
                                                      input logic [OFF_W-1:0] off);
        case (sz)
            SZ_BYTE: return LANES'(1) << off;
            SZ_HALF: return off[1] ? 4'b1100 : 4'b0011;
            default: return {LANES{1'b1}};
        endcase
    endfunction

    function automatic logic [DW-1:0] lanes_to_mask(input logic [LANES-1:0] en);
        logic [DW-1:0] m;
        for (int i = 0; i < LANES; i++) begin
            m[8*i +: 8] = {8{en[i]}};
        end
        return m;
    endfunction

    function automatic logic [DW-1:0] replicate(input acc_size_e sz,
                                                input logic [DW-1:0] d);
        case (sz)
            SZ_BYTE: return {LANES{d[7:0]}};
            SZ_HALF: return {2{d[15:0]}};
            default: return d;
        endcase
    endfunction

    function automatic store_lane_t build_store(input acc_size_e sz,
                                                input logic [OFF_W-1:0] off,
                                                input logic [DW-1:0] d);
        store_lane_t s;
        s.lanes = lane_enables(sz, off);
        s.mask  = lanes_to_mask(s.lanes);
        s.data  = replicate(sz, d);
        return s;
    endfunction

    function automatic logic [DW-1:0] extract(input acc_size_e sz,
                                              input logic [OFF_W-1:0] off,
                                              input logic [DW-1:0] w);
        case (sz)
            SZ_BYTE: return (w >> {off, 3'b000}) & 32'h0000_00FF;
            SZ_HALF: return (w >> {off[1], 4'b0000}) & 32'h0000_FFFF;
            default: return w;
        endcase
    endfunction

endpackage

// File: rtl/dcwb_tag_ram.sv
module dcwb_tag_ram #(
    parameter int          IDX_W   = 11,
    parameter int          TAG_W   = 19,
    parameter logic [TAG_W-1:0] RST_TAG = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_dirty,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_dirty
);
    localparam int DEPTH = 1 << IDX_W;

    logic [TAG_W-1:0] tags  [DEPTH];
    logic             dirty [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                tags[i]  <= RST_TAG;
                dirty[i] <= 1'b0;
            end
        end else if (wr_en) begin
            tags[idx]  <= wr_tag;
            dirty[idx] <= wr_dirty;
        end
    end

    assign rd_tag   = tags[idx];
    assign rd_dirty = dirty[idx];

endmodule

// File: rtl/dcwb_data_ram.sv
module dcwb_data_ram #(
    parameter int IDX_W = 11,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] idx,
    output logic [DW-1:0]    rd_word,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_word
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DW-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            words[idx] <= wr_word;
        end
    end

    assign rd_word = words[idx];

endmodule

// File: rtl/dcwb_ctrl.sv
module dcwb_ctrl
    import dcwb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    req,
    input  logic    cacheable,
    input  logic    hit,
    input  logic    victim_dirty,
    input  logic    mem_ack,
    output cstate_e state
);
    cstate_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: begin
                if (req) begin
                    if (!cacheable)        nxt = ST_BYP;
                    else if (!hit)         nxt = victim_dirty ? ST_WB : ST_FILL;
                end
            end
            ST_WB:   if (mem_ack) nxt = ST_FILL;
            ST_FILL: if (mem_ack) nxt = ST_IDLE;
            ST_BYP:  if (mem_ack) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    AST_WB_BEFORE_FILL: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WB && mem_ack) |=> (state == ST_FILL)); // R5

    AST_CLEAN_MISS_NO_WB: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && req && cacheable && !hit && !victim_dirty) |=> (state == ST_FILL)); // R6

endmodule

// File: rtl/dcwb_cache.sv
module dcwb_cache
    import dcwb_pkg::*;
#(
    parameter int          IDX_W        = 11,
    parameter logic [31:0] RD_MASK      = 32'hFE00_0000,
    parameter logic [31:0] RD_BASE      = 32'h1000_0000,
    parameter logic [31:0] WR_MASK      = 32'hF000_0000,
    parameter logic [31:0] WR_BASE      = 32'h1000_0000,
    parameter logic [31:0] TAG_RST_WORD = 32'hFFFF_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [1:0]  cpu_size,
    input  logic [31:0] cpu_addr,
    input  logic [31:0] cpu_wdata,
    output logic [31:0] cpu_rdata,
    output logic        cpu_busy,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [3:0]  mem_be,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack
);
    localparam int TAG_W = AW - IDX_W - OFF_W;
    localparam int TAG_LO = IDX_W + OFF_W;
    localparam logic [TAG_W-1:0] RST_TAG = TAG_RST_WORD[AW-1:TAG_LO];

    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] atag;
    logic [OFF_W-1:0] off;
    acc_size_e        sz;
    store_lane_t      st;

    logic [TAG_W-1:0] rd_tag;
    logic             rd_dirty;
    logic [DW-1:0]    rd_word;
    logic             tag_we, tag_dirty_in;
    logic [TAG_W-1:0] tag_in;
    logic             dat_we;
    logic [DW-1:0]    dat_in;

    logic    in_rd_win, in_wr_win, cacheable, hit;
    logic    hit_done, fill_done, byp_done;
    cstate_e state;

    assign idx  = cpu_addr[TAG_LO-1:OFF_W];
    assign atag = cpu_addr[AW-1:TAG_LO];
    assign off  = cpu_addr[OFF_W-1:0];
    assign sz   = to_size(cpu_size);
    assign st   = build_store(sz, off, cpu_wdata);

    assign in_rd_win = (cpu_addr & RD_MASK) == RD_BASE;
    assign in_wr_win = (cpu_addr & WR_MASK) == WR_BASE;
    assign cacheable = cpu_we ? in_wr_win : in_rd_win;
    assign hit       = (rd_tag == atag);

    assign hit_done  = (state == ST_IDLE) && cpu_req && cacheable && hit;
    assign fill_done = (state == ST_FILL) && mem_ack;
    assign byp_done  = (state == ST_BYP)  && mem_ack;

    dcwb_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .req          (cpu_req),
        .cacheable    (cacheable),
        .hit          (hit),
        .victim_dirty (rd_dirty),
        .mem_ack      (mem_ack),
        .state        (state)
    );

    dcwb_tag_ram #(
        .IDX_W   (IDX_W),
        .TAG_W   (TAG_W),
        .RST_TAG (RST_TAG)
    ) u_tags (
        .clk      (clk),
        .rst      (rst),
        .idx      (idx),
        .rd_tag   (rd_tag),
        .rd_dirty (rd_dirty),
        .wr_en    (tag_we),
        .wr_tag   (tag_in),
        .wr_dirty (tag_dirty_in)
    );

    dcwb_data_ram #(
        .IDX_W (IDX_W),
        .DW    (DW)
    ) u_data (
        .clk     (clk),
        .idx     (idx),
        .rd_word (rd_word),
        .wr_en   (dat_we),
        .wr_word (dat_in)
    );

    // Array updates: a fill installs a clean line, a store hit merges and dirties it
    always_comb begin
        tag_we       = 1'b0;
        tag_in       = atag;
        tag_dirty_in = 1'b0;
        dat_we       = 1'b0;
        dat_in       = mem_rdata;
        if (fill_done) begin
            tag_we = 1'b1;
            dat_we = 1'b1;
        end else if (hit_done && cpu_we) begin
            tag_we       = 1'b1;
            tag_dirty_in = 1'b1;
            dat_we       = 1'b1;
            dat_in       = (rd_word & ~st.mask) | (st.data & st.mask);
        end
    end

    // Memory port
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {cpu_addr[AW-1:OFF_W], {OFF_W{1'b0}}};
        mem_be    = '1;
        mem_wdata = '0;
        case (state)
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {rd_tag, idx, {OFF_W{1'b0}}};
                mem_wdata = rd_word;
            end
            ST_FILL: mem_req = 1'b1;
            ST_BYP: begin
                mem_req   = 1'b1;
                mem_we    = cpu_we;
                mem_be    = cpu_we ? st.lanes : {LANES{1'b1}};
                mem_wdata = st.data;
            end
            default: ;
        endcase
    end

    assign cpu_rdata = (state == ST_BYP) ? extract(sz, off, mem_rdata)
                                         : extract(sz, off, rd_word);
    assign cpu_busy  = cpu_req && !(hit_done || byp_done);

    AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R11

    AST_HIT_NO_MEMORY: assert property (@(posedge clk) disable iff (rst)
        hit_done |=> (state == ST_IDLE && !mem_req)); // R4

    AST_FILL_INSTALLS_TAG: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FILL && mem_ack) |=> (!cpu_req || hit)); // R2

    AST_FILL_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FILL && mem_ack) |=> (!cpu_req || !rd_dirty)); // R7

endmodule

// File: tb/dcwb_cache_test.sv
module dcwb_cache_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [1:0]  cpu_size = 2'd2;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_busy;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int errors = 0, checks = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    dcwb_cache uut (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_busy(cpu_busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // ---------------- memory model with transaction log ----------------
    logic [31:0] mem_img [logic [31:0]];
    logic        lg_we   [16];
    logic [31:0] lg_addr [16];
    logic [31:0] lg_data [16];
    logic [3:0]  lg_be   [16];
    int          lg_n = 0;
    int          wcnt = 0;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return a ^ 32'hC3A5_0F96 ^ {a[15:0], a[31:16]};
    endfunction

    function automatic logic [31:0] mem_peek(input logic [31:0] a);
        if (mem_img.exists(a)) return mem_img[a];
        return pat(a);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            wcnt    <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (wcnt == 1) begin
                wcnt    <= 0;
                mem_ack <= 1'b1;
                if (mem_we) begin
                    logic [31:0] old, m;
                    old = mem_peek(mem_addr);
                    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{mem_be[i]}};
                    mem_img[mem_addr] = (old & ~m) | (mem_wdata & m);
                end else begin
                    mem_rdata <= mem_peek(mem_addr);
                end
                lg_we[lg_n % 16]   <= mem_we;
                lg_addr[lg_n % 16] <= mem_addr;
                lg_data[lg_n % 16] <= mem_wdata;
                lg_be[lg_n % 16]   <= mem_be;
                lg_n <= lg_n + 1;
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic access(input bit we, input logic [1:0] sz, input logic [31:0] a,
                          input logic [31:0] wd, output logic [31:0] rd, output int cyc);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_size = sz; cpu_addr = a; cpu_wdata = wd;
        cyc = 0;
        forever begin
            #5;
            cyc++;
            if (!cpu_busy) begin
                rd = cpu_rdata;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        checks++; errors++;
        $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
        finish_run();
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] rd, w4, w5;
        int cyc, b;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #5;
        chk("R1 reset busy", {31'd0, cpu_busy}, 32'd0);
        chk("R1 reset mem_req", {31'd0, mem_req}, 32'd0);

        // R1/R6: first cached load is a clean miss, fill only
        b = lg_n;
        access(0, 2'd2, 32'h1000_0010, 0, rd, cyc);
        chk("R1 miss data", rd, pat(32'h1000_0010));
        chk("R6 clean miss txn count", lg_n - b, 1);
        chk("R1 fill is read", {31'd0, lg_we[b % 16]}, 32'd0);
        chk("R1 fill addr", lg_addr[b % 16], 32'h1000_0010);
        chk("R11 busy during miss", {31'd0, cyc > 1}, 32'd1);

        // R4: hit in one cycle, no memory traffic
        b = lg_n;
        access(0, 2'd2, 32'h1000_0010, 0, rd, cyc);
        chk("R4 hit cycles", cyc, 1);
        chk("R4 hit data", rd, pat(32'h1000_0010));
        chk("R4 hit no txn", lg_n - b, 0);

        // R10: sub-word loads, every lane
        for (int k = 0; k < 4; k++) begin
            access(0, 2'd0, 32'h1000_0010 + k, 0, rd, cyc);
            chk("R10 byte load", rd, (pat(32'h1000_0010) >> (8 * k)) & 32'hFF);
        end
        for (int k = 0; k < 4; k += 2) begin
            access(0, 2'd1, 32'h1000_0010 + k, 0, rd, cyc);
            chk("R10 half load", rd, (pat(32'h1000_0010) >> (8 * k)) & 32'hFFFF);
        end

        // R9: byte store sweep, junk in upper data bits
        b = lg_n;
        w4 = pat(32'h1000_0020);
        for (int k = 0; k < 4; k++) begin
            access(1, 2'd0, 32'h1000_0020 + k, 32'hABCD_EF00 | (32'h30 + k), rd, cyc);
            w4[8*k +: 8] = 8'h30 + k;
        end
        access(0, 2'd2, 32'h1000_0020, 0, rd, cyc);
        chk("R9 byte merge", rd, w4);
        chk("R7 store miss absorbed txn count", lg_n - b, 1);
        chk("R7 store miss no write", {31'd0, lg_we[b % 16]}, 32'd0);

        // R8: halfword store on both halves
        w5 = pat(32'h1000_0040);
        access(1, 2'd1, 32'h1000_0042, 32'h5555_1202, rd, cyc);
        w5[31:16] = 16'h1202;
        chk("R8 upper half merge", mem_peek(32'h1000_0040), pat(32'h1000_0040));
        access(0, 2'd2, 32'h1000_0040, 0, rd, cyc);
        chk("R8 upper half only", rd, w5);
        access(1, 2'd1, 32'h1000_0040, 32'h7777_1200, rd, cyc);
        w5[15:0] = 16'h1200;
        access(0, 2'd2, 32'h1000_0040, 0, rd, cyc);
        chk("R8 both halves", rd, w5);

        // R5/R2: conflict 0x2000 away evicts dirty line first
        b = lg_n;
        access(0, 2'd2, 32'h1000_2020, 0, rd, cyc);
        chk("R2 conflict data", rd, pat(32'h1000_2020));
        chk("R5 txn count", lg_n - b, 2);
        chk("R5 first is write", {31'd0, lg_we[b % 16]}, 32'd1);
        chk("R5 wb addr", lg_addr[b % 16], 32'h1000_0020);
        chk("R5 wb data", lg_data[b % 16], w4);
        chk("R5 wb byte enables", {28'd0, lg_be[b % 16]}, 32'hF);
        chk("R5 then fill read", {31'd0, lg_we[(b + 1) % 16]}, 32'd0);
        chk("R5 fill addr", lg_addr[(b + 1) % 16], 32'h1000_2020);

        // R6: clean victim, fill only; data came back through memory
        b = lg_n;
        access(0, 2'd2, 32'h1000_0020, 0, rd, cyc);
        chk("R6 refetched data", rd, w4);
        chk("R6 clean conflict txn count", lg_n - b, 1);
        b = lg_n;
        access(0, 2'd2, 32'h1000_4010, 0, rd, cyc);
        chk("R6 clean conflict 2 txn count", lg_n - b, 1);
        chk("R2 conflict addr", lg_addr[b % 16], 32'h1000_4010);

        // R3: bypassed loads
        for (int r = 0; r < 2; r++) begin
            b = lg_n;
            access(0, 2'd2, 32'h2000_0008, 0, rd, cyc);
            chk("R3 io load data", rd, pat(32'h2000_0008));
            chk("R3 io load txn", lg_n - b, 1);
            b = lg_n;
            access(0, 2'd2, 32'h1200_0000, 0, rd, cyc);
            chk("R3 load outside read window txn", lg_n - b, 1);
        end
        access(0, 2'd1, 32'h2000_0006, 0, rd, cyc);
        chk("R10 bypass half load", rd, (pat(32'h2000_0004) >> 16) & 32'hFFFF);

        // R3: bypassed byte store
        b = lg_n;
        access(1, 2'd0, 32'h2000_0003, 32'h0000_00AB, rd, cyc);
        chk("R3 io store txn", lg_n - b, 1);
        chk("R3 io store addr", lg_addr[b % 16], 32'h2000_0000);
        chk("R3 io store be", {28'd0, lg_be[b % 16]}, 32'h8);
        chk("R3 io store lane", {24'd0, lg_data[b % 16][31:24]}, 32'hAB);

        // R3/R7: store in write window but outside read window is cached
        b = lg_n;
        access(1, 2'd2, 32'h1200_0004, 32'hCAFE_F00D, rd, cyc);
        chk("R3 cached store txn count", lg_n - b, 1);
        chk("R7 cached store no write", {31'd0, lg_we[b % 16]}, 32'd0);
        access(0, 2'd2, 32'h1200_0004, 0, rd, cyc);
        chk("R3 load bypasses cache", rd, pat(32'h1200_0004));

        // R5/R7: evict that dirty line via index 1
        b = lg_n;
        access(0, 2'd2, 32'h1000_0004, 0, rd, cyc);
        chk("R7 dirty evict wb addr", lg_addr[b % 16], 32'h1200_0004);
        chk("R7 dirty evict wb data", lg_data[b % 16], 32'hCAFE_F00D);
        chk("R5 evict order", {31'd0, lg_we[(b + 1) % 16]}, 32'd0);

        // Sweep over 32 lines: store, hit readback, conflicting eviction
        for (int i = 0; i < 32; i++) begin
            logic [31:0] a, d;
            a = 32'h1001_0000 + i * 4;
            d = 32'h9000_0000 + i * 32'h0001_0203;
            access(1, 2'd2, a, d, rd, cyc);
            access(0, 2'd2, a, 0, rd, cyc);
            chk("R4 sweep hit cycles", cyc, 1);
            chk("R4 sweep hit data", rd, d);
            b = lg_n;
            access(0, 2'd2, a + 32'h6000, 0, rd, cyc);
            chk("R5 sweep wb addr", lg_addr[b % 16], a);
            chk("R5 sweep wb data", lg_data[b % 16], d);
            chk("R2 sweep new data", rd, pat(a + 32'h6000));
        end

        finish_run();
    end

endmodule